// File: doc/BRIEF.md
# Three-State Dynamic Power Manager

This block decides which of three power states a system should occupy: a full-speed running state, a low-power idle state and a deep sleep state. An observer stage watches a busy indication from the workload and counts consecutive idle cycles. A sequencing controller compares that count against two thresholds supplied on input ports and uses the result, together with an interrupt input and a wake-up event input, to issue state commands.

Each move between states carries its own latency, set as a cycle-count parameter. The four moves have four separate parameters. Entering or leaving idle is short, entering sleep is longer, and waking from sleep is by far the slowest. While a move is in progress, the block raises a transitioning flag and ignores new events. The commanded target appears on the command output as soon as the move starts. The reported state, and the power code derived from it, change only when the latency has elapsed.

Idle and sleep are left by different events. Idle returns to running only on an interrupt. Sleep returns to running only on a wake-up event. The one exception is an interrupt that arrives while sleep is being entered: it is held and triggers the wake sequence as soon as the entry finishes.

Top module: `pm_power_manager`

## Requirements
- R1: While reset is high at a clock edge, and after that edge, the block reports state RUN (code 0) and command RUN (code 0), with transitioning low and power code 3.
- R2: The state and command codes are RUN=0, IDLE=1 and SLEEP=2. The power code follows the settled state, ordered by consumption: 3 in RUN, 1 in IDLE, 0 in SLEEP.
- R3: In settled RUN, once busy_i has been sampled low on idle_thr_i consecutive edges, the move to IDLE starts on the next edge. A single edge with busy_i high restarts the count.
- R4: In settled IDLE with no interrupt, once busy_i has been sampled low on sleep_thr_i consecutive edges, the move to SLEEP starts on the next edge.
- R5: Settled IDLE moves to RUN only when irq_i is sampled high, and an interrupt takes priority over the sleep threshold. wake_i and busy_i never cause this move.
- R6: Settled SLEEP moves to RUN only when wake_i is sampled high, or when an interrupt was held during entry (R9). irq_i and busy_i sampled in settled SLEEP have no effect.
- R7: A move keeps the transitioning output high for exactly its latency parameter in cycles. RUN to IDLE, IDLE to RUN, IDLE to SLEEP and SLEEP to RUN each have their own parameter. The command output shows the target from the first transitioning cycle onward. The state output and the power code update on the cycle in which transitioning falls.
- R8: While transitioning is high, irq_i, wake_i and the idle count start no new move. The move completes to its original target.
- R9: If irq_i is sampled high during a move into SLEEP, SLEEP is reported for one cycle after entry completes, and the SLEEP to RUN move starts on the following edge. A wake_i pulse during the entry is not held.
- R10: Reset asserted during a move abandons it and returns the block to settled RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Workload busy indication; low counts as an idle cycle |
| idle_thr_i | input | CW | Consecutive idle cycles needed to leave RUN for IDLE |
| sleep_thr_i | input | CW | Consecutive idle cycles needed to leave IDLE for SLEEP |
| irq_i | input | 1 | Interrupt; the only exit from IDLE |
| wake_i | input | 1 | Wake-up event; the exit from SLEEP |
| cmd_o | output | 2 | Commanded target state code |
| state_o | output | 2 | Settled state code |
| pcode_o | output | 2 | Power level code of the settled state |
| xfer_o | output | 1 | High while a move is in progress |

## Verification
The bench builds the block with a 4-bit idle counter and latencies of 2, 3, 4 and 6 cycles for the four moves, so every move's full window fits in a few cycles and can be checked cycle by cycle. With these short latencies, the bench sweeps the RUN-to-IDLE threshold from 1 to 6 and the IDLE-to-SLEEP threshold from 1 to 4. For each value it computes the start edge and the completion edge arithmetically. The small latencies also make it cheap to place an interrupt or a wake pulse inside a move, to check that events are dropped and that an interrupt during sleep entry is held, and to assert reset partway through a move.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_SLEEP = 2'd2
  } pstate_e;

  // Power code ordered by consumption: higher code, more power.
  function automatic logic [1:0] power_code(input pstate_e s);
    case (s)
      PS_RUN:   return 2'd3;
      PS_IDLE:  return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pm_observer.sv
// Counts consecutive idle cycles of the workload, saturating at the top.
module pm_observer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i || busy_i) begin
      cnt_o <= '0;
    end else if (cnt_o != CMAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R3: the count only grows, saturates or clears; it never wraps
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_o) != '0) |-> (cnt_o == '0 || cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/pm_latency_timer.sv
// Down-counter that holds a move in progress for a loaded number of cycles.
module pm_latency_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          active_o,
  output logic          done_o
);

  logic [TW-1:0] remain;

  assign done_o = active_o && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      remain   <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      remain   <= load_val_i - 1'b1;
    end else if (active_o) begin
      if (remain == '0) active_o <= 1'b0;
      else              remain   <= remain - 1'b1;
    end
  end

  // R8: the controller never reloads the timer while a move is running
  p_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active_o);

  // R7: the last counted cycle ends the move
  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !active_o);

endmodule

// File: rtl/pm_sequencer.sv
// Power state controller: picks the next state and the latency of each move.
module pm_sequencer
  import pm_pkg::*;
#(
  parameter int CW             = 8,
  parameter int TW             = 12,
  parameter int LAT_RUN2IDLE   = 10,
  parameter int LAT_IDLE2RUN   = 10,
  parameter int LAT_IDLE2SLEEP = 90,
  parameter int LAT_SLEEP2RUN  = 4000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_i,
  input  logic          wake_i,
  input  logic [CW-1:0] idle_cnt_i,
  input  logic [CW-1:0] idle_thr_i,
  input  logic [CW-1:0] sleep_thr_i,
  input  logic          active_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [TW-1:0] load_val_o,
  output logic [1:0]    cmd_o,
  output logic [1:0]    state_o,
  output logic [1:0]    pcode_o
);

  localparam logic [TW-1:0] V_RUN2IDLE   = TW'(LAT_RUN2IDLE);
  localparam logic [TW-1:0] V_IDLE2RUN   = TW'(LAT_IDLE2RUN);
  localparam logic [TW-1:0] V_IDLE2SLEEP = TW'(LAT_IDLE2SLEEP);
  localparam logic [TW-1:0] V_SLEEP2RUN  = TW'(LAT_SLEEP2RUN);

  pstate_e cur, tgt, nxt;
  logic    pend;

  always_comb begin
    start_o    = 1'b0;
    nxt        = cur;
    load_val_o = '0;
    if (!active_i) begin
      case (cur)
        PS_RUN: begin
          if (idle_cnt_i >= idle_thr_i) begin
            start_o    = 1'b1;
            nxt        = PS_IDLE;
            load_val_o = V_RUN2IDLE;
          end
        end
        PS_IDLE: begin
          if (irq_i) begin
            start_o    = 1'b1;
            nxt        = PS_RUN;
            load_val_o = V_IDLE2RUN;
          end else if (idle_cnt_i >= sleep_thr_i) begin
            start_o    = 1'b1;
            nxt        = PS_SLEEP;
            load_val_o = V_IDLE2SLEEP;
          end
        end
        PS_SLEEP: begin
          if (wake_i || pend) begin
            start_o    = 1'b1;
            nxt        = PS_RUN;
            load_val_o = V_SLEEP2RUN;
          end
        end
        default: begin
          start_o    = 1'b1;
          nxt        = PS_RUN;
          load_val_o = V_IDLE2RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= PS_RUN;
      tgt     <= PS_RUN;
      pend    <= 1'b0;
      pcode_o <= power_code(PS_RUN);
    end else begin
      if (start_o) tgt <= nxt;
      if (done_i) begin
        cur     <= tgt;
        pcode_o <= power_code(tgt);
      end
      if (start_o && cur == PS_SLEEP)
        pend <= 1'b0;
      else if (active_i && tgt == PS_SLEEP && irq_i)
        pend <= 1'b1;
    end
  end

  assign cmd_o   = tgt;
  assign state_o = cur;

  // R7: during a move the command names a state other than the settled one
  p_cmd_target_r7: assert property (@(posedge clk) disable iff (rst)
    active_i |-> (tgt != cur));

  // R7: when settled, command and state agree
  p_settled_match_r7: assert property (@(posedge clk) disable iff (rst)
    !active_i |-> (tgt == cur));

  // R7: the reported state changes only at the end of a move
  p_change_after_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur != $past(cur)) |-> $past(active_i));

  // R4: only the four legal moves ever occur
  p_legal_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur != $past(cur)) |->
      (($past(cur) == PS_RUN && cur == PS_IDLE) ||
       ($past(cur) == PS_IDLE && cur != PS_IDLE) ||
       ($past(cur) == PS_SLEEP && cur == PS_RUN)));

  // R5: without an interrupt, settled IDLE never heads for RUN
  p_idle_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_IDLE && !active_i && !irq_i) |=> (tgt != PS_RUN));

  // R6: without a wake event or held interrupt, settled SLEEP stays put
  p_sleep_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (cur == PS_SLEEP && !active_i && !wake_i && !pend) |=> !active_i);

endmodule

// File: rtl/pm_power_manager.sv
module pm_power_manager
  import pm_pkg::*;
#(
  parameter int CW             = 8,
  parameter int LAT_RUN2IDLE   = 10,
  parameter int LAT_IDLE2RUN   = 10,
  parameter int LAT_IDLE2SLEEP = 90,
  parameter int LAT_SLEEP2RUN  = 4000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic [CW-1:0] idle_thr_i,
  input  logic [CW-1:0] sleep_thr_i,
  input  logic          irq_i,
  input  logic          wake_i,
  output logic [1:0]    cmd_o,
  output logic [1:0]    state_o,
  output logic [1:0]    pcode_o,
  output logic          xfer_o
);

  localparam int LMAX = max4(LAT_RUN2IDLE, LAT_IDLE2RUN, LAT_IDLE2SLEEP, LAT_SLEEP2RUN);
  localparam int TW   = $clog2(LMAX + 1);

  logic [CW-1:0] idle_cnt;
  logic          start;
  logic [TW-1:0] load_val;
  logic          active, done;

  pm_observer #(.CW(CW)) u_obs (
    .clk    (clk),
    .rst    (rst),
    .busy_i (busy_i),
    .clr_i  (active | start),
    .cnt_o  (idle_cnt)
  );

  pm_latency_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start),
    .load_val_i (load_val),
    .active_o   (active),
    .done_o     (done)
  );

  pm_sequencer #(
    .CW             (CW),
    .TW             (TW),
    .LAT_RUN2IDLE   (LAT_RUN2IDLE),
    .LAT_IDLE2RUN   (LAT_IDLE2RUN),
    .LAT_IDLE2SLEEP (LAT_IDLE2SLEEP),
    .LAT_SLEEP2RUN  (LAT_SLEEP2RUN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .irq_i       (irq_i),
    .wake_i      (wake_i),
    .idle_cnt_i  (idle_cnt),
    .idle_thr_i  (idle_thr_i),
    .sleep_thr_i (sleep_thr_i),
    .active_i    (active),
    .done_i      (done),
    .start_o     (start),
    .load_val_o  (load_val),
    .cmd_o       (cmd_o),
    .state_o     (state_o),
    .pcode_o     (pcode_o)
  );

  assign xfer_o = active;

  // R2: the power code always matches the settled state
  p_pcode_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && pcode_o == 2'd3) ||
    (state_o == 2'd1 && pcode_o == 2'd1) ||
    (state_o == 2'd2 && pcode_o == 2'd0));

endmodule

// File: tb/pm_power_manager_test.sv
module pm_power_manager_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 4;
  localparam int L_RI = 2;
  localparam int L_IR = 3;
  localparam int L_IS = 4;
  localparam int L_SR = 6;
  localparam int S_RUN = 0, S_IDLE = 1, S_SLEEP = 2;

  logic clk = 1'b0;
  logic rst, busy, irq, wake;
  logic [CW-1:0] ithr, sthr;
  logic [1:0] cmd, state, pcode;
  logic xfer;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_power_manager #(
    .CW(CW), .LAT_RUN2IDLE(L_RI), .LAT_IDLE2RUN(L_IR),
    .LAT_IDLE2SLEEP(L_IS), .LAT_SLEEP2RUN(L_SR)
  ) uut (
    .clk(clk), .rst(rst), .busy_i(busy), .idle_thr_i(ithr), .sleep_thr_i(sthr),
    .irq_i(irq), .wake_i(wake), .cmd_o(cmd), .state_o(state), .pcode_o(pcode),
    .xfer_o(xfer)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settled(input string req, input int s);
    chk(req, "state", int'(state), s);
    chk(req, "cmd", int'(cmd), s);
    chk(req, "xfer", int'(xfer), 0);
    chk(req, "pcode", int'(pcode), (s == S_RUN) ? 3 : (s == S_IDLE) ? 1 : 0);
  endtask

  // R3 / R7: RUN to IDLE after n idle edges (busy must have been high on the prior edge)
  task automatic go_idle(input int n);
    ithr = CW'(n);
    busy = 1'b0;
    for (int k = 1; k <= n; k++) begin
      tick();
      chk("R3", "xfer before threshold", int'(xfer), 0);
    end
    for (int k = 1; k <= L_RI; k++) begin
      tick();
      chk("R7", "xfer run->idle", int'(xfer), 1);
      chk("R7", "cmd run->idle", int'(cmd), S_IDLE);
      chk("R7", "state held run", int'(state), S_RUN);
    end
    tick();
    settled("R2", S_IDLE);
    busy = 1'b1;
  endtask

  // R5 / R7: interrupt takes settled IDLE back to RUN
  task automatic wake_from_idle();
    irq = 1'b1;
    tick();
    irq = 1'b0;
    chk("R5", "xfer on irq", int'(xfer), 1);
    chk("R5", "cmd on irq", int'(cmd), S_RUN);
    for (int k = 2; k <= L_IR; k++) begin
      tick();
      chk("R7", "state held idle", int'(state), S_IDLE);
    end
    tick();
    settled("R7", S_RUN);
  endtask

  // R4 / R7: IDLE to SLEEP after m idle edges
  task automatic go_sleep(input int m);
    sthr = CW'(m);
    busy = 1'b0;
    for (int k = 1; k <= m; k++) begin
      tick();
      chk("R4", "xfer before sleep threshold", int'(xfer), 0);
    end
    for (int k = 1; k <= L_IS; k++) begin
      tick();
      chk("R7", "xfer idle->sleep", int'(xfer), 1);
      chk("R7", "cmd idle->sleep", int'(cmd), S_SLEEP);
    end
    tick();
    settled("R2", S_SLEEP);
    busy = 1'b1;
    sthr = '1;
  endtask

  // R6 / R7: wake event takes settled SLEEP to RUN
  task automatic wake_from_sleep();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R6", "xfer on wake", int'(xfer), 1);
    chk("R6", "cmd on wake", int'(cmd), S_RUN);
    for (int k = 2; k <= L_SR; k++) begin
      tick();
      chk("R7", "state held sleep", int'(state), S_SLEEP);
    end
    tick();
    settled("R7", S_RUN);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; busy = 1'b1; irq = 1'b0; wake = 1'b0;
    ithr = '1; sthr = '1;
    repeat (3) tick();
    settled("R1", S_RUN);
    rst = 1'b0;
    tick();
    settled("R1", S_RUN);

    // R3 threshold sweep with return via interrupt
    for (int n = 1; n <= 6; n++) begin
      go_idle(n);
      tick();
      wake_from_idle();
      tick();
    end

    // R3: one busy edge restarts the count
    ithr = 4'd4;
    busy = 1'b0;
    repeat (3) tick();
    busy = 1'b1;
    tick();
    chk("R3", "no move after busy", int'(xfer), 0);
    busy = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R3", "restarted count", int'(xfer), 0);
    end
    tick();
    chk("R3", "start after full count", int'(xfer), 1);
    busy = 1'b1;
    repeat (L_RI) tick();
    settled("R3", S_IDLE);
    wake_from_idle();
    tick();

    // R8: irq during RUN->IDLE is dropped
    ithr = 4'd2;
    busy = 1'b0;
    repeat (3) tick();
    chk("R8", "xfer started", int'(xfer), 1);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    busy = 1'b1;
    tick();
    repeat (4) tick();
    settled("R8", S_IDLE);

    // R5: wake and busy do not leave IDLE
    wake = 1'b1;
    for (int k = 0; k < 6; k++) begin
      busy = k[0];
      tick();
    end
    wake = 1'b0;
    busy = 1'b1;
    tick();
    settled("R5", S_IDLE);

    // R5: interrupt wins over a reached sleep threshold
    sthr = 4'd1;
    busy = 1'b0;
    tick();
    irq = 1'b1;
    tick();
    irq = 1'b0;
    busy = 1'b1;
    chk("R5", "irq priority cmd", int'(cmd), S_RUN);
    sthr = '1;
    repeat (L_IR) tick();
    settled("R5", S_RUN);
    tick();

    // R4 sleep threshold sweep, R6 ignore checks, wake
    for (int m = 1; m <= 4; m++) begin
      go_idle(1);
      tick();
      go_sleep(m);
      irq = 1'b1;
      busy = 1'b0;
      repeat (3) tick();
      irq = 1'b0;
      busy = 1'b1;
      tick();
      settled("R6", S_SLEEP);
      wake_from_sleep();
      tick();
    end

    // R9: irq during sleep entry is held
    go_idle(1);
    tick();
    sthr = 4'd2;
    busy = 1'b0;
    repeat (3) tick();
    chk("R9", "entry started", int'(cmd), S_SLEEP);
    busy = 1'b1;
    irq = 1'b1;
    tick();
    irq = 1'b0;
    sthr = '1;
    repeat (2) tick();
    chk("R9", "still entering", int'(xfer), 1);
    tick();
    settled("R9", S_SLEEP);
    tick();
    chk("R9", "wake starts", int'(xfer), 1);
    chk("R9", "wake cmd", int'(cmd), S_RUN);
    repeat (L_SR - 1) tick();
    chk("R9", "wake in progress", int'(state), S_SLEEP);
    tick();
    settled("R9", S_RUN);
    tick();

    // R9: wake pulse during sleep entry is not held
    go_idle(1);
    tick();
    sthr = 4'd2;
    busy = 1'b0;
    repeat (3) tick();
    busy = 1'b1;
    wake = 1'b1;
    tick();
    wake = 1'b0;
    sthr = '1;
    repeat (3) tick();
    repeat (5) tick();
    settled("R9", S_SLEEP);
    wake_from_sleep();
    tick();

    // R10: reset during a move
    ithr = 4'd1;
    busy = 1'b0;
    repeat (2) tick();
    chk("R10", "move in progress", int'(xfer), 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    busy = 1'b1;
    settled("R10", S_RUN);
    tick();
    settled("R10", S_RUN);

    summary();
    $finish;
  end

endmodule